// File: doc/BRIEF.md
# Real-Time Clock with Alarm Compare

This block keeps time of day and day of week for a chip that sleeps most of the time. A slow tick-enable input, nominally 32768 pulses per second, passes through a prescaler. The prescaler produces one step per second. That step advances a chain of four counters: seconds, minutes, hours and day of week. Each counter counts either in plain binary or in packed BCD, under the control of one mode bit.

Four alarm set points sit beside the counters, one per counter. An enable mask chooses which of them take part in the compare. The alarm flag is not tracked continuously. It is sampled only after a counter step, or after software locks the clock again following an edit. The flag drives an interrupt, and it records whether the alarm arrived while the sleep input was high.

Software reaches the block over a byte-wide register bus. The bus has a 4-bit address, single-cycle write and read strobes, and a combinational read-data path. Reading the control register returns the status bits and clears them in the same access. Writing the control register restarts the prescaler, so the seconds boundary can be aligned to an outside reference.

Register map:

| Address | Register |
|---------|----------|
| 0 | seconds |
| 1 | minutes |
| 2 | hours |
| 3 | day of week |
| 4 to 7 | alarm set points, in the same field order as addresses 0 to 3 |
| 8 | alarm field mask |
| 9 | control |

Top module: `rtc_alarm_ctl`

## Requirements
- R1: After reset, seconds, minutes and hours read 0 and day of week reads 1. The alarm field mask reads 0. Control bits 0, 1, 2 and 4 read 0.
- R2: The alarm field mask at address 8 is read/write in bits 3:0: bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day of week. Bits 7:4 always read 0.
- R3: Counting is active only while control bit 0 (unlock) is 0. In that state the seconds counter advances exactly once per TICKS_PER_SEC tick-enable pulses. Any write to the control register at address 9 restarts the prescaler count from zero.
- R4: With control bit 1 at 0 (binary), the counters roll over as follows. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into day of week. Day of week goes from 7 to 1.
- R5: With control bit 1 at 1, all counters count in BCD. The limits are 0x59, 0x59, 0x23 and 0x07. A low digit of 9 steps to 0 and carries into the high digit.
- R6: Writes to addresses 0 to 3 take effect only while unlock is 1, and are ignored while it is 0. While unlock is 1 the counters do not advance.
- R7: An alarm match requires every enabled field to equal its set point. If the mask is 0, no alarm is ever raised.
- R8: The alarm flag, control bit 4, is set only in two cases. The first is a match sampled just after a seconds step. The second is a match sampled just after a control write that changes unlock from 1 to 0. Changing a set point alone never sets the flag.
- R9: A read of the control register returns the flag values as they were before the read. It then clears the alarm flag (bit 4) and the wake flag (bit 3).
- R10: The irq output is 1 exactly while both the alarm flag and control bit 2 (interrupt enable) are 1.
- R11: When the alarm flag is set while sleep_i is 1, the wake flag (control bit 3) is set too. The wake flag keeps its value through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle slow timebase pulse |
| sleep_i | input | 1 | High while the CPU is asleep |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Alarm interrupt |

## Verification
The bound checker watches several properties on every cycle:
- the mask register's upper nibble always reads as zero;
- the alarm flag rises only right after a step or relock event;
- a control read clears the flag;
- the mask at zero never lets the flag rise;
- the seconds counter holds while unlocked unless it is written.

The rest can only be shown by the bench's scenarios:
- the counter limits in both encodings, with carries through every field;
- prescaler alignment after a control write;
- the pre-clear read value;
- the interrupt gating;
- the wake flag surviving reset.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and the counter step function for the real-time clock.
// Assumes an 8-bit field per time register and a 4-bit register address.
package rtc_alarm_pkg;
    localparam int ADDR_W   = 4;
    localparam int FIELDS   = 4;

    localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
    localparam logic [ADDR_W-1:0] A_AEN  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd9;
    localparam logic [ADDR_W-1:0] A_SET0 = 4'd4;

    localparam int CB_UNLOCK = 0;
    localparam int CB_BCD    = 1;
    localparam int CB_INTEN  = 2;
    localparam int CB_WAKE   = 3;
    localparam int CB_ALARM  = 4;

    // Next value of one time field: wrap at the limit, BCD digit carry, else +1.
    function automatic logic [7:0] step_val(input logic [7:0] v, input logic [7:0] lim,
                                            input logic [7:0] low, input logic bcd);
        if (v == lim)
            return low;
        else if (bcd && v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the slow tick-enable pulses to one step per DIV pulses.
// Assumes DIV >= 2; restart clears the running count at once.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic pulse
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Step output on the last tick of each period.
    assign pulse = tick && (cnt == LAST);

    // Tick counter with restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (tick)
            cnt <= pulse ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_time_field.sv
// One time counter field (seconds, minutes, hours or day of week).
// Counts in binary or BCD; a direct write wins over a step in the same cycle.
module rtc_time_field
    import rtc_alarm_pkg::*;
#(
    parameter logic [7:0] LIM_BIN = 8'd59,
    parameter logic [7:0] LIM_BCD = 8'h59,
    parameter logic [7:0] LOW     = 8'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bcd,
    input  logic       step_in,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] val,
    output logic       step_out
);
    logic [7:0] lim;

    // Limit follows the active encoding; carry when stepping at the limit.
    assign lim      = bcd ? LIM_BCD : LIM_BIN;
    assign step_out = step_in && (val == lim);

    // Field register: reset, software write, or counting step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= LOW;
        else if (wr)
            val <= wdata;
        else if (step_in)
            val <= step_val(val, lim, LOW, bcd);
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Compares the time fields with the set points over the enabled fields only.
// No enabled field means no match.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [FIELDS-1:0][7:0] now,
    input  logic [FIELDS-1:0][7:0] setp,
    input  logic [FIELDS-1:0]      en,
    output logic                   hit
);
    logic [FIELDS-1:0] ok;

    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_cmp
            // A disabled field always passes.
            assign ok[g] = !en[g] || (now[g] == setp[g]);
        end
    endgenerate

    // All enabled fields equal, and at least one is enabled.
    assign hit = (|en) && (&ok);
endmodule

// File: rtl/rtc_alarm_ctl.sv
// Real-time clock top: prescaler, four counters, alarm compare, register bus.
// Assumes single-cycle strobes; rdata is combinational and shows pre-clear status.
module rtc_alarm_ctl
    import rtc_alarm_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              sleep_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam logic [FIELDS-1:0][7:0] LIM_B = {8'd7, 8'd23, 8'd59, 8'd59};
    localparam logic [FIELDS-1:0][7:0] LIM_D = {8'h07, 8'h23, 8'h59, 8'h59};
    localparam logic [FIELDS-1:0][7:0] LOWV  = {8'd1, 8'd0, 8'd0, 8'd0};

    logic                   unlock_q, bcd_q, inten_q, alarm_q, wake_q, evt_q;
    logic [FIELDS-1:0]      aen_q;
    logic [FIELDS-1:0][7:0] setp_q;
    logic [FIELDS-1:0][7:0] t_val;
    logic [FIELDS:0]        step;
    logic                   sec_pulse, hit, ctrl_wr, ctrl_rd, relock;
    logic [7:0]             t_sec;

    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign ctrl_rd = rd_en && (addr == A_CTRL);
    assign relock  = ctrl_wr && unlock_q && !wdata[CB_UNLOCK];
    assign step[0] = sec_pulse && !unlock_q;
    assign t_sec   = t_val[0];

    rtc_prescaler #(.DIV(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .restart(ctrl_wr), .pulse(sec_pulse)
    );

    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_fld
            rtc_time_field #(.LIM_BIN(LIM_B[g]), .LIM_BCD(LIM_D[g]), .LOW(LOWV[g])) u_fld (
                .clk(clk), .rst_n(rst_n), .bcd(bcd_q), .step_in(step[g]),
                .wr(wr_en && unlock_q && (addr == ADDR_W'(g))),
                .wdata(wdata), .val(t_val[g]), .step_out(step[g+1])
            );

            // Alarm set point register for this field.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    setp_q[g] <= '0;
                else if (wr_en && addr == A_SET0 + ADDR_W'(g))
                    setp_q[g] <= wdata;
            end
        end
    endgenerate

    rtc_alarm_match u_match (.now(t_val), .setp(setp_q), .en(aen_q), .hit(hit));

    // Control bits and mask; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
            bcd_q    <= 1'b0;
            inten_q  <= 1'b0;
            aen_q    <= '0;
        end else begin
            if (ctrl_wr) begin
                unlock_q <= wdata[CB_UNLOCK];
                bcd_q    <= wdata[CB_BCD];
                inten_q  <= wdata[CB_INTEN];
            end
            if (wr_en && addr == A_AEN)
                aen_q <= wdata[FIELDS-1:0];
        end
    end

    // Compare window one cycle after a step or relock, once counters settle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else
            evt_q <= step[0] || relock;
    end

    // Alarm flag: set on sampled match, cleared by control read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= 1'b0;
        else if (evt_q && hit)
            alarm_q <= 1'b1;
        else if (ctrl_rd)
            alarm_q <= 1'b0;
    end

    // Wake flag: no reset, so it survives a wake-up reset.
    always_ff @(posedge clk) begin
        if (evt_q && hit && sleep_i)
            wake_q <= 1'b1;
        else if (ctrl_rd)
            wake_q <= 1'b0;
    end

    assign irq = alarm_q && inten_q;

    // Read data multiplexer.
    always_comb begin
        rdata = 8'h00;
        if (addr < ADDR_W'(FIELDS))
            rdata = t_val[addr[1:0]];
        else if (addr < ADDR_W'(2 * FIELDS))
            rdata = setp_q[addr[1:0]];
        else if (addr == A_AEN)
            rdata = {4'h0, aen_q};
        else if (addr == A_CTRL)
            rdata = {3'b000, alarm_q, wake_q, inten_q, bcd_q, unlock_q};
    end
endmodule

// File: rtl/rtc_alarm_chk.sv
// Checker for rtc_alarm_ctl, attached by bind; observes bus and flag state.
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        rdata,
    input logic              unlock,
    input logic              alarm,
    input logic              evt,
    input logic [3:0]        aen,
    input logic [7:0]        sec
);
    p_mask_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_AEN) |-> rdata[7:4] == 4'h0);

    p_flag_only_on_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(evt));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CTRL && !evt) |=> !alarm);

    p_hold_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && !(wr_en && addr == A_SEC)) |=> $stable(sec));

    p_no_mask_no_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (aen == 4'h0) |=> !$rose(alarm));
endmodule

bind rtc_alarm_ctl rtc_alarm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .unlock(unlock_q), .alarm(alarm_q), .evt(evt_q),
    .aen(aen_q), .sec(t_sec)
);

// File: tb/test_rtc_alarm_ctl.sv
`timescale 1ns/1ps
// Bench for rtc_alarm_ctl: rollover vector table, then directed scenarios.
module test_rtc_alarm_ctl;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, sleep_i = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         checks = 0, errors = 0;
    logic [7:0] r;

    always #2.5 clk = ~clk;

    rtc_alarm_ctl #(.TICKS_PER_SEC(DIV)) i_rtc_alarm_ctl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sleep_i(sleep_i),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    // bcd, s, m, h, d, expected s, m, h, d after one second
    localparam logic [8:0][7:0] VEC [8] = '{
        {8'd0, 8'd59, 8'd59, 8'd23, 8'd7, 8'd0,  8'd0,  8'd0,  8'd1},
        {8'd0, 8'd59, 8'd10, 8'd5,  8'd3, 8'd0,  8'd11, 8'd5,  8'd3},
        {8'd0, 8'd30, 8'd59, 8'd23, 8'd2, 8'd31, 8'd59, 8'd23, 8'd2},
        {8'd0, 8'd59, 8'd59, 8'd22, 8'd4, 8'd0,  8'd0,  8'd23, 8'd4},
        {8'd1, 8'h59, 8'h59, 8'h23, 8'h7, 8'h0,  8'h0,  8'h0,  8'h1},
        {8'd1, 8'h09, 8'h00, 8'h00, 8'h1, 8'h10, 8'h0,  8'h0,  8'h1},
        {8'd1, 8'h59, 8'h19, 8'h09, 8'h2, 8'h0,  8'h20, 8'h9,  8'h2},
        {8'd1, 8'h59, 8'h59, 8'h09, 8'h5, 8'h0,  8'h0,  8'h10, 8'h5}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
        end
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_time(input logic bcd, input logic [7:0] s, input logic [7:0] m,
                            input logic [7:0] h, input logic [7:0] d);
        wr(4'd9, {6'd0, bcd, 1'b1});
        wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, d);
        wr(4'd9, {6'd0, bcd, 1'b0});
    endtask

    task automatic relock(input logic [7:0] base);
        wr(4'd9, base | 8'h01);
        wr(4'd9, base);
        idle(3);
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state (wake bit masked: not reset)
        rd(4'd0, r); chk("R1 sec", r, 8'd0);
        rd(4'd1, r); chk("R1 min", r, 8'd0);
        rd(4'd2, r); chk("R1 hrs", r, 8'd0);
        rd(4'd3, r); chk("R1 dow", r, 8'd1);
        rd(4'd8, r); chk("R1 mask", r, 8'd0);
        rd(4'd9, r); chk("R1 ctrl", r & 8'hF7, 8'd0);

        // R2 mask reserved bits
        wr(4'd8, 8'hFF); rd(4'd8, r); chk("R2 mask", r, 8'h0F);
        wr(4'd8, 8'h00);

        // R4, R5 rollover vector table
        for (int v = 0; v < 8; v++) begin
            set_time(VEC[v][8][0], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
            ticks(DIV);
            idle(1);
            for (int f = 0; f < 4; f++) begin
                rd(4'(f), r);
                chk(VEC[v][8][0] ? "R5 bcd step" : "R4 bin step", r, VEC[v][3-f]);
            end
        end

        // R3 prescaler period and restart on control write
        set_time(1'b0, 8'd10, 8'd0, 8'd0, 8'd1);
        ticks(DIV - 1); rd(4'd0, r); chk("R3 before period", r, 8'd10);
        ticks(1); rd(4'd0, r); chk("R3 one period", r, 8'd11);
        ticks(2); wr(4'd9, 8'h00);
        ticks(2); rd(4'd0, r); chk("R3 restarted", r, 8'd11);
        ticks(2); rd(4'd0, r); chk("R3 realigned", r, 8'd12);

        // R6 write ignored while locked; counting held while unlocked
        wr(4'd0, 8'd40); rd(4'd0, r); chk("R6 locked write", r, 8'd12);
        wr(4'd9, 8'h01); ticks(DIV * 2); rd(4'd0, r); chk("R6 held", r, 8'd12);
        wr(4'd0, 8'd20); rd(4'd0, r); chk("R6 unlocked write", r, 8'd20);
        wr(4'd9, 8'h00);
        rd(4'd9, r);

        // R10/R9 alarm on step with interrupt enable
        wr(4'd4, 8'd21); wr(4'd8, 8'h01); wr(4'd9, 8'h04);
        rd(4'd9, r);
        ticks(DIV); idle(3);
        checks++; if (irq !== 1'b1) begin errors++; $display("FAIL R10 irq: got %b expected 1", irq); end
        rd(4'd9, r); chk("R9 pre-clear", r & 8'hF7, 8'h14);
        rd(4'd9, r); chk("R9 cleared", r & 8'hF7, 8'h04);
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R9 irq: got %b expected 0", irq); end

        // R8 set point change alone does not set flag; relock does
        wr(4'd4, 8'd22); wr(4'd4, 8'd21); idle(4);
        rd(4'd9, r); chk("R8 no event", r & 8'hF7, 8'h04);
        relock(8'h04);
        rd(4'd9, r); chk("R8 relock", r & 8'hF7, 8'h14);

        // R7 all enabled fields must match; empty mask never alarms
        wr(4'd5, 8'd99); wr(4'd8, 8'h03); relock(8'h00);
        rd(4'd9, r); chk("R7 partial", r & 8'hF7, 8'h00);
        wr(4'd5, 8'd0); wr(4'd8, 8'h00); relock(8'h00);
        rd(4'd9, r); chk("R7 empty mask", r & 8'hF7, 8'h00);
        wr(4'd8, 8'h02); relock(8'h00);
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R10 gated: got %b expected 0", irq); end
        rd(4'd9, r); chk("R7 minute only", r & 8'hF7, 8'h10);

        // R11 wake flag set during sleep and kept through reset
        sleep_i = 1'b1;
        relock(8'h00);
        sleep_i = 1'b0;
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        rd(4'd9, r); chk("R11 wake kept", r, 8'h08);
        rd(4'd9, r); chk("R11 wake cleared", r, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule